// File: doc/BRIEF.md
# External bus idle cycle inserter

This block sits between the access scheduler of a multi-chip-select external memory controller and the bus sequencer. It decides how many idle clock cycles must separate a finished access from the next one, and grants the next access only once that gap has elapsed. Two independent delay sources run in parallel. The first is a turnaround count owned by the access that ends, which only applies to certain combinations of access kind, chip-select and address/data multiplexing. The second is a cycle-to-cycle count owned by the access that starts, which is enabled separately for a repeat on the same chip-select and for a switch from another chip-select. The gap that is inserted is the larger of the delays that apply.

The sequencer reports each completed access with a one-cycle end strobe carrying its kind and chip-select, raised once the chip-select has been released. Gap counting starts at that strobe. A request carries the kind and chip-select of the next access and is held until a one-cycle grant answers it. The sequencer's control lines pass through a registered gate that forces them to zero whenever no granted access is in flight, so all controls are inactive during inserted idle cycles.

Top module: `idle_gap_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, grant, hold and bus_ctrl are all zero.
- R2: When no access has ended since reset, a request sampled at a clock edge is granted on the next cycle with no idle cycles.
- R3: If the end strobe is sampled at edge E, a request first sampled at edge E+1+p and a gap of N cycles apply, grant is high for the single cycle after edge E+1+max(N,p). The cycles counted since the strobe saturate at 2^CNT_W-1.
- R4: After a read whose chip-select had a nonzero turnaround count T, the turnaround T applies before a write on any chip-select, before any access when that chip-select was in multiplexed mode, and before a read on a different chip-select; it does not apply to a read on the same chip-select in non-multiplexed mode.
- R5: After a write, no turnaround cycles are applied to the following access of either kind.
- R6: When the same-chip-select enable of the requested chip-select is set and the previous access used the same chip-select, the requested chip-select's cycle-to-cycle count C applies.
- R7: When the different-chip-select enable of the requested chip-select is set and the previous access used another chip-select, the requested chip-select's cycle-to-cycle count C applies.
- R8: When both a turnaround and a cycle-to-cycle count apply, the gap is the larger of the two; when neither applies the gap is zero.
- R9: The turnaround count and multiplexed flag of an ending access are captured at its end strobe; changing them afterwards does not alter the gap that follows it.
- R10: Grant is a one-cycle pulse, and no further grant is given between a grant and the next end strobe, even if a request stays high.
- R11: bus_ctrl equals seq_ctrl delayed one cycle while a granted access is in flight (from the grant up to and including the end strobe cycle) and is zero otherwise, including every idle cycle before a grant.
- R12: hold is high on each cycle on which a sampled request is being delayed by the gap, and low on the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_turn_cnt | input | NUM_CS*CNT_W | Turnaround count per chip-select, slice i for chip-select i |
| cfg_turn_muxed | input | NUM_CS | Address/data multiplexed mode per chip-select |
| cfg_c2c_cnt | input | NUM_CS*CNT_W | Cycle-to-cycle count per chip-select |
| cfg_c2c_same_en | input | NUM_CS | Apply cycle-to-cycle count when repeating the same chip-select |
| cfg_c2c_diff_en | input | NUM_CS | Apply cycle-to-cycle count when arriving from another chip-select |
| end_valid | input | 1 | One-cycle strobe: an access has released its chip-select |
| end_write | input | 1 | Kind of the ending access, 1 write, 0 read |
| end_cs | input | CS_W | Chip-select of the ending access |
| req_valid | input | 1 | Next access requested, held until granted |
| req_write | input | 1 | Kind of the requested access, 1 write, 0 read |
| req_cs | input | CS_W | Chip-select of the requested access |
| seq_ctrl | input | CTRL_W | Control lines from the sequencer, active high |
| grant | output | 1 | One-cycle grant of the pending request |
| hold | output | 1 | A request is being delayed by the idle gap |
| bus_ctrl | output | CTRL_W | Gated, registered control lines to the bus |

## Verification
The checker assumes the sequencer side behaves: a request stays high with a stable kind and chip-select until its grant, and an end strobe arrives only for an access that was granted, at least one cycle after the grant. Under those assumptions it holds that grants are single pulses, one per access, only after a sampled request, and that hold never coincides with a grant or with active controls. The bench keeps within these assumptions by issuing every request from one access task that waits for the grant, keeps the access open for several cycles and only then raises the end strobe; configuration is changed only between the strobe and the next request, while seq_ctrl is driven with nonzero values throughout so that gating is visible.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  // Turnaround of the ending access is owed only when a read hands the bus
  // to a write, to a multiplexed bus, or to another device.
  function automatic logic turn_owed(input acc_kind_e prev_kind,
                                     input logic      prev_muxed,
                                     input logic      same_cs,
                                     input acc_kind_e next_kind);
    return (prev_kind == ACC_READ) &&
           (prev_muxed || (next_kind == ACC_WRITE) || !same_cs);
  endfunction

endpackage

// File: rtl/gap_history.sv
module gap_history
  import idle_gap_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             end_valid,
  input  acc_kind_e        end_kind,
  input  logic [CS_W-1:0]  end_cs,
  input  logic [CNT_W-1:0] turn_cnt [NUM_CS],
  input  logic [NUM_CS-1:0] turn_muxed,
  output logic             prev_valid,
  output acc_kind_e        prev_kind,
  output logic [CS_W-1:0]  prev_cs,
  output logic [CNT_W-1:0] prev_turn,
  output logic             prev_muxed,
  output logic [CNT_W-1:0] elapsed
);

  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_kind  <= ACC_READ;
      prev_cs    <= '0;
      prev_turn  <= '0;
      prev_muxed <= 1'b0;
      elapsed    <= SAT;
    end else if (end_valid) begin
      // ending access settings are frozen here
      prev_valid <= 1'b1;
      prev_kind  <= end_kind;
      prev_cs    <= end_cs;
      prev_turn  <= turn_cnt[end_cs];
      prev_muxed <= turn_muxed[end_cs];
      elapsed    <= '0;
    end else if (elapsed != SAT) begin
      elapsed <= elapsed + 1'b1;
    end
  end

endmodule

// File: rtl/gap_need.sv
module gap_need
  import idle_gap_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic              prev_valid,
  input  acc_kind_e         prev_kind,
  input  logic [CS_W-1:0]   prev_cs,
  input  logic [CNT_W-1:0]  prev_turn,
  input  logic              prev_muxed,
  input  acc_kind_e         req_kind,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [CNT_W-1:0]  c2c_cnt [NUM_CS],
  input  logic [NUM_CS-1:0] c2c_same_en,
  input  logic [NUM_CS-1:0] c2c_diff_en,
  output logic [CNT_W-1:0]  need
);

  logic             same_cs;
  logic [CNT_W-1:0] turn_part;
  logic [CNT_W-1:0] c2c_part;

  always_comb begin
    same_cs   = (req_cs == prev_cs);
    turn_part = turn_owed(prev_kind, prev_muxed, same_cs, req_kind) ? prev_turn : '0;
    c2c_part  = '0;
    if (same_cs ? c2c_same_en[req_cs] : c2c_diff_en[req_cs])
      c2c_part = c2c_cnt[req_cs];
    if (!prev_valid)
      need = '0;
    else
      need = (turn_part > c2c_part) ? turn_part : c2c_part;
  end

endmodule

// File: rtl/gap_grant.sv
module gap_grant #(
  parameter int CNT_W  = 4,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              end_valid,
  input  logic [CNT_W-1:0]  elapsed,
  input  logic [CNT_W-1:0]  need,
  input  logic [CTRL_W-1:0] seq_ctrl,
  output logic              grant,
  output logic              hold,
  output logic [CTRL_W-1:0] bus_ctrl
);

  logic busy_q;
  logic ready;
  logic launch;

  always_comb begin
    ready  = (elapsed >= need);
    launch = req_valid && !busy_q && ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      grant    <= 1'b0;
      hold     <= 1'b0;
      bus_ctrl <= '0;
    end else begin
      grant    <= launch;
      hold     <= req_valid && !busy_q && !ready;
      bus_ctrl <= busy_q ? seq_ctrl : '0;
      if (launch)
        busy_q <= 1'b1;
      else if (end_valid)
        busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/idle_gap_ctrl.sv
module idle_gap_ctrl
  import idle_gap_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  parameter int CTRL_W = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CS*CNT_W-1:0] cfg_turn_cnt,
  input  logic [NUM_CS-1:0]       cfg_turn_muxed,
  input  logic [NUM_CS*CNT_W-1:0] cfg_c2c_cnt,
  input  logic [NUM_CS-1:0]       cfg_c2c_same_en,
  input  logic [NUM_CS-1:0]       cfg_c2c_diff_en,
  input  logic                    end_valid,
  input  logic                    end_write,
  input  logic [CS_W-1:0]         end_cs,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [CS_W-1:0]         req_cs,
  input  logic [CTRL_W-1:0]       seq_ctrl,
  output logic                    grant,
  output logic                    hold,
  output logic [CTRL_W-1:0]       bus_ctrl
);

  logic [CNT_W-1:0] turn_arr [NUM_CS];
  logic [CNT_W-1:0] c2c_arr  [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
    assign turn_arr[i] = cfg_turn_cnt[i*CNT_W +: CNT_W];
    assign c2c_arr[i]  = cfg_c2c_cnt[i*CNT_W +: CNT_W];
  end

  acc_kind_e        end_kind;
  acc_kind_e        req_kind;
  logic             prev_valid;
  acc_kind_e        prev_kind;
  logic [CS_W-1:0]  prev_cs;
  logic [CNT_W-1:0] prev_turn;
  logic             prev_muxed;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] need;

  assign end_kind = acc_kind_e'(end_write);
  assign req_kind = acc_kind_e'(req_write);

  gap_history #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .end_valid  (end_valid),
    .end_kind   (end_kind),
    .end_cs     (end_cs),
    .turn_cnt   (turn_arr),
    .turn_muxed (cfg_turn_muxed),
    .prev_valid (prev_valid),
    .prev_kind  (prev_kind),
    .prev_cs    (prev_cs),
    .prev_turn  (prev_turn),
    .prev_muxed (prev_muxed),
    .elapsed    (elapsed)
  );

  gap_need #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W)) u_need (
    .prev_valid  (prev_valid),
    .prev_kind   (prev_kind),
    .prev_cs     (prev_cs),
    .prev_turn   (prev_turn),
    .prev_muxed  (prev_muxed),
    .req_kind    (req_kind),
    .req_cs      (req_cs),
    .c2c_cnt     (c2c_arr),
    .c2c_same_en (cfg_c2c_same_en),
    .c2c_diff_en (cfg_c2c_diff_en),
    .need        (need)
  );

  gap_grant #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_grant (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .end_valid (end_valid),
    .elapsed   (elapsed),
    .need      (need),
    .seq_ctrl  (seq_ctrl),
    .grant     (grant),
    .hold      (hold),
    .bus_ctrl  (bus_ctrl)
  );

endmodule

// File: rtl/idle_gap_ctrl_chk.sv
module idle_gap_ctrl_chk #(
  parameter int CTRL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              end_valid,
  input logic              grant,
  input logic              hold,
  input logic [CTRL_W-1:0] bus_ctrl
);

  logic open_q;

  always_ff @(posedge clk) begin
    if (rst)
      open_q <= 1'b0;
    else if (end_valid)
      open_q <= 1'b0;
    else if (grant)
      open_q <= 1'b1;
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant);

  a_r10_one_per_access: assert property (@(posedge clk) disable iff (rst)
    open_q |-> !grant);

  a_r2_grant_after_req: assert property (@(posedge clk) disable iff (rst)
    grant |-> $past(req_valid));

  a_r12_hold_not_grant: assert property (@(posedge clk) disable iff (rst)
    hold |-> !grant);

  a_r11_quiet_when_held: assert property (@(posedge clk) disable iff (rst)
    hold |-> (bus_ctrl == '0));

endmodule

bind idle_gap_ctrl idle_gap_ctrl_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .end_valid (end_valid),
  .grant     (grant),
  .hold      (hold),
  .bus_ctrl  (bus_ctrl)
);

// File: tb/sim_idle_gap_ctrl.sv
module sim_idle_gap_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 4;
  localparam int CNT_W  = 4;
  localparam int CTRL_W = 4;
  localparam int CS_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CS*CNT_W-1:0] cfg_turn_cnt;
  logic [NUM_CS-1:0]       cfg_turn_muxed;
  logic [NUM_CS*CNT_W-1:0] cfg_c2c_cnt;
  logic [NUM_CS-1:0]       cfg_c2c_same_en;
  logic [NUM_CS-1:0]       cfg_c2c_diff_en;
  logic end_valid = 1'b0;
  logic end_write = 1'b0;
  logic [CS_W-1:0] end_cs = '0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [CS_W-1:0] req_cs = '0;
  logic [CTRL_W-1:0] seq_ctrl = 4'hA;
  logic grant, hold;
  logic [CTRL_W-1:0] bus_ctrl;

  int turn [NUM_CS];
  bit mux  [NUM_CS];
  int c2c  [NUM_CS];
  bit sen  [NUM_CS];
  bit den  [NUM_CS];

  bit p_valid = 0;
  bit p_wr = 0;
  int p_cs = 0;
  int p_turn = 0;
  bit p_mux = 0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) begin
      cfg_turn_cnt[i*CNT_W +: CNT_W] = CNT_W'(turn[i]);
      cfg_c2c_cnt[i*CNT_W +: CNT_W]  = CNT_W'(c2c[i]);
      cfg_turn_muxed[i]  = mux[i];
      cfg_c2c_same_en[i] = sen[i];
      cfg_c2c_diff_en[i] = den[i];
    end
  end

  idle_gap_ctrl #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .CTRL_W(CTRL_W)) u0 (
    .clk(clk), .rst(rst),
    .cfg_turn_cnt(cfg_turn_cnt), .cfg_turn_muxed(cfg_turn_muxed),
    .cfg_c2c_cnt(cfg_c2c_cnt), .cfg_c2c_same_en(cfg_c2c_same_en),
    .cfg_c2c_diff_en(cfg_c2c_diff_en),
    .end_valid(end_valid), .end_write(end_write), .end_cs(end_cs),
    .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .seq_ctrl(seq_ctrl), .grant(grant), .hold(hold), .bus_ctrl(bus_ctrl)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // gap from the requirements: turnaround of the ended access vs c2c of the new one
  function automatic int model_need(input bit wr, input int cs);
    int t, c;
    bit same;
    if (!p_valid) return 0;
    same = (cs == p_cs);
    t = (!p_wr && p_turn > 0 && (p_mux || wr || !same)) ? p_turn : 0;
    c = 0;
    if (same && sen[cs]) c = c2c[cs];
    if (!same && den[cs]) c = c2c[cs];
    return (t > c) ? t : c;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_access(input bit wr, input int cs, input int pre,
                            input bit keep_req, input string tag);
    int need, exp_w, w;
    logic [CTRL_W-1:0] sc;
    repeat (pre) tick();
    need  = model_need(wr, cs);
    exp_w = ((need > pre) ? need - pre : 0) + 1;
    req_valid = 1'b1;
    req_write = wr;
    req_cs    = CS_W'(cs);
    w = 0;
    while (w < 40) begin
      tick();
      w++;
      check(bus_ctrl == '0, "R11", "bus_ctrl while idle", int'(bus_ctrl), 0);
      check(hold == !grant, "R12", "hold while waiting", int'(hold), int'(!grant));
      if (grant) break;
    end
    check(w == exp_w, tag, "cycles to grant", w, exp_w);
    if (!keep_req) req_valid = 1'b0;
    sc = CTRL_W'($urandom_range(1, 15));
    seq_ctrl = sc;
    tick();
    check(grant == 1'b0, "R10", "grant pulse width", int'(grant), 0);
    check(bus_ctrl == sc, "R11", "bus_ctrl in flight", int'(bus_ctrl), int'(sc));
    repeat (2) begin
      tick();
      check(grant == 1'b0, "R10", "grant during access", int'(grant), 0);
    end
    req_valid = 1'b0;
    end_valid = 1'b1;
    end_write = wr;
    end_cs    = CS_W'(cs);
    p_valid = 1; p_wr = wr; p_cs = cs; p_turn = turn[cs]; p_mux = mux[cs];
    tick();
    end_valid = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NUM_CS; i++) begin
      turn[i] = 0; mux[i] = 0; c2c[i] = 0; sen[i] = 0; den[i] = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_cfg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grant == 0 && hold == 0 && bus_ctrl == 0, "R1", "outputs in reset",
          int'({grant, hold, bus_ctrl}), 0);
    rst = 1'b0;
    tick();
    check(grant == 0 && hold == 0 && bus_ctrl == 0, "R1", "outputs after reset",
          int'({grant, hold, bus_ctrl}), 0);

    turn[0] = 3;
    run_access(0, 0, 0, 0, "R2");          // nothing recorded yet
    run_access(0, 0, 0, 0, "R4");          // read->read same cs, not muxed: 0
    run_access(0, 1, 0, 0, "R4");          // read->read other cs: 3
    turn[1] = 2; mux[1] = 1;
    run_access(0, 1, 0, 0, "R4");          // muxed same cs: captured 0 at prior strobe -> 0
    run_access(1, 1, 0, 1, "R4");          // read cs1 (turn 2, muxed) -> write: 2
    run_access(0, 2, 0, 0, "R5");          // after write: 0
    c2c[2] = 4; sen[2] = 1;
    run_access(0, 2, 0, 0, "R6");          // same cs c2c: 4
    c2c[3] = 5; den[3] = 1;
    turn[3] = 6;
    run_access(1, 3, 0, 0, "R7");          // other cs c2c: 5
    run_access(0, 3, 0, 0, "R5");          // after write, same cs, no same_en: 0
    c2c[0] = 2; den[0] = 1;
    run_access(1, 0, 0, 0, "R8");          // max(6,2)=6
    turn[0] = 1; c2c[0] = 7; sen[0] = 1;
    run_access(0, 0, 0, 0, "R8");          // after write: c2c 7
    c2c[1] = 3; den[1] = 1;
    run_access(0, 1, 0, 0, "R8");          // max(1,3)=3; strobe captures turn 2, muxed
    turn[1] = 0; mux[1] = 0;
    run_access(0, 1, 0, 0, "R9");          // captured muxed turn 2 still applies
    c2c[2] = 8; den[2] = 1;
    run_access(0, 2, 3, 0, "R3");          // gap 8, request 3 cycles late
    run_access(1, 3, 20, 0, "R3");         // gap 5 long passed, count saturated

    for (int n = 0; n < 150; n++) begin
      for (int i = 0; i < NUM_CS; i++) begin
        turn[i] = $urandom_range(0, 15);
        mux[i]  = 1'($urandom_range(0, 1));
        c2c[i]  = $urandom_range(0, 15);
        sen[i]  = 1'($urandom_range(0, 1));
        den[i]  = 1'($urandom_range(0, 1));
      end
      run_access(1'($urandom_range(0, 1)), $urandom_range(0, NUM_CS-1),
                 ($urandom_range(0, 9) == 0) ? 20 : $urandom_range(0, 4),
                 1'($urandom_range(0, 1)), "R8");
      // ending settings change after the strobe; model keeps the captured ones (R9)
      turn[p_cs] = $urandom_range(0, 15);
      mux[p_cs]  = 1'($urandom_range(0, 1));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule